// File: doc/BRIEF.md
# Co-processor Channel Register Bank

This block is the memory-mapped register bank of a four-channel co-processor. It sits behind a simple 32-bit register bus with address, write data, write strobe, read strobe and read data. It holds a global control register, a global status register, a channel control register and one window of four registers for each channel. It hands every writable field to the rest of the co-processor as a decoded output.

Every register answers on four neighbouring word addresses. The first replaces the writable bits. The second ORs the written ones in, the third clears the written ones, and the fourth inverts them. Software can therefore flip single bits without a read-modify-write. The channel engines report completion with one-cycle pulses. These pulses latch per-channel flags in the status register, and the bank masks the flags with the per-channel interrupt enables to form one interrupt line. A soft-reset bit in the control register returns the whole bank to its reset state for as long as it stays set.

Top module: `coproc_regbank`

## Requirements
- R1: Address bits 3:2 select the access type. A write with bits 3:2 = 00 replaces the writable bits of the selected register with the write data. Address bits 1:0 must be zero for a write or read to hit any register.
- R2: A write with address bits 3:2 = 01 ORs the write data into the writable bits of the register.
- R3: A write with address bits 3:2 = 10 clears, in the writable bits, every bit that is 1 in the write data.
- R4: A write with address bits 3:2 = 11 inverts, in the writable bits, every bit that is 1 in the write data.
- R5: The control register is at 0x000. Its writable bits are:
  - 31: soft reset
  - 30: clock gate
  - 23: gather-result write
  - 22: context cache
  - 21: context switch
  - 3:0: per-channel interrupt enable

  Bits 29 and 28 read as the CIPHER_PRESENT and HASH_PRESENT parameters, and writes never change them. All other bits read zero.
- R6: Status bits 3:0, at register 0x010, are per-channel interrupt flags. A pulse on a channel's done input sets its flag at the next clock edge. Only a write to the clear alias 0x018 lowers a flag. Direct, set and toggle writes to 0x010 leave the flags unchanged. A done pulse in the same cycle as a clear of the same flag leaves the flag set.
- R7: Status bits 19:16 show the channel-ready inputs, bits 27:24 show the current-channel input and bit 28 shows the key-ready input. These bits are read-only.
- R8: The channel control register is at 0x020. Bits 3:0 are channel enables, bits 11:8 are high-priority marks and bit 16 merges the channel 0 interrupt. All other bits read zero.
- R9: Channel n has a window at 0x100 + n*0x40. Within the window:
  - 0x00: command pointer (32 bits)
  - 0x10: semaphore (low SEMA_W bits kept, upper bits read zero)
  - 0x20: channel status (32 bits)
  - 0x30: options (32 bits)

  Each register drives its own output.
- R10: irq_o is high exactly when some status flag and its control interrupt enable are both 1.
- R11: While control bit 31 reads 1, at each clock edge every other register and flag returns to zero and writes to them have no effect. Bit 31 stays set until software clears it.
- R12: Reads return the plain register value through any of its four alias addresses. Reads of unmapped or misaligned addresses return zero. A read changes no state, and bus_rdata is zero while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| ch_done_i | input | NUM_CH | Per-channel completion pulses |
| ch_ready_i | input | NUM_CH | Per-channel ready levels shown in status |
| cur_ch_i | input | 4 | Number of the channel currently served |
| key_ready_i | input | 1 | Fixed key is ready |
| soft_rst_o | output | 1 | Soft reset bit |
| clk_gate_o | output | 1 | Clock gate bit |
| gather_wr_o | output | 1 | Gather-result write option |
| ctx_cache_o | output | 1 | Context cache enable |
| ctx_switch_o | output | 1 | Context switch enable |
| ch_enable_o | output | NUM_CH | Channel enables |
| ch_high_prio_o | output | NUM_CH | Channel high-priority marks |
| ch0_irq_merge_o | output | 1 | Channel 0 interrupt merge |
| cmd_ptr_o | output | NUM_CH*32 | Command pointers, channel n at bits n*32 |
| sema_o | output | NUM_CH*SEMA_W | Semaphores, channel n at bits n*SEMA_W |
| ch_status_o | output | NUM_CH*32 | Channel status registers |
| ch_opts_o | output | NUM_CH*32 | Channel option registers |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with ADDR_W=12, NUM_CH=4, SEMA_W=6, CIPHER_PRESENT=1 and HASH_PRESENT=0. The narrow semaphore makes the truncation of its upper bits visible. The unequal presence constants make a swap of bits 29 and 28, or a write that reaches them, show up on a read. With all four channels built, every window, the first address after the last window and every enable/flag pair of the interrupt mask are within reach of both the directed cases and the random mix.

// File: rtl/regbank_pkg.sv
// Shared definitions for the channel register bank.
// Holds the alias access codes, the address map constants and the
// masked read-modify-write helper that every register uses.
package regbank_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_SET   = 2'b01,
        OP_CLR   = 2'b10,
        OP_TGL   = 2'b11
    } alias_op_e;

    localparam int CH_BASE   = 256;
    localparam int CH_STRIDE = 64;
    localparam int REGS_PER_CH = 4;
    localparam int GLOBAL_REGS = 3;

    // Combine the current value with write data according to the alias code,
    // touching only the bits in mask.
    function automatic logic [31:0] alias_apply(
        input logic [31:0] cur,
        input logic [31:0] wd,
        input logic [31:0] mask,
        input alias_op_e   op
    );
        logic [31:0] nv;
        case (op)
            OP_WRITE: nv = wd;
            OP_SET:   nv = cur | wd;
            OP_CLR:   nv = cur & ~wd;
            default:  nv = cur ^ wd;
        endcase
        return (cur & ~mask) | (nv & mask);
    endfunction

endpackage

// File: rtl/regbank_addr_dec.sv
// Address decoder for the register bank.
// Turns a byte address into a one-hot register select and an alias code.
// Assumes word-aligned accesses; any address with bits 1:0 set selects
// nothing. Select bit order: 0 control, 1 status, 2 channel control,
// then 3 + 4*channel + register within the window.
module regbank_addr_dec
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 4,
    localparam int SEL_N = GLOBAL_REGS + REGS_PER_CH * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [SEL_N-1:0]  sel,
    output alias_op_e         op
);

    localparam int WIN_FIRST = CH_BASE / CH_STRIDE;

    // Pick the alias code from the two bits above the byte offset.
    assign op = alias_op_e'(addr[3:2]);

    // Match the word address against every mapped register.
    always_comb begin
        sel = '0;
        if (addr[1:0] == 2'b00) begin
            for (int g = 0; g < GLOBAL_REGS; g++) begin
                if (addr[ADDR_W-1:4] == (ADDR_W-4)'(g)) sel[g] = 1'b1;
            end
            for (int c = 0; c < NUM_CH; c++) begin
                for (int r = 0; r < REGS_PER_CH; r++) begin
                    if (addr[ADDR_W-1:6] == (ADDR_W-6)'(WIN_FIRST + c) &&
                        addr[5:4] == 2'(r))
                        sel[GLOBAL_REGS + REGS_PER_CH*c + r] = 1'b1;
                end
            end
        end
    end

    // R1: an address never selects more than one register.
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/regbank_chan_win.sv
// One channel's register window: command pointer, semaphore, status, options.
// Assumes a one-hot select from the decoder; soft reset has priority
// over any write and clears all four registers.
module regbank_chan_win
    import regbank_pkg::*;
#(
    parameter int SEMA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  srst,
    input  logic                  we,
    input  logic [REGS_PER_CH-1:0] sel,
    input  alias_op_e             op,
    input  logic [31:0]           wdata,
    output logic [31:0]           ptr_o,
    output logic [SEMA_W-1:0]     sema_o,
    output logic [31:0]           stat_o,
    output logic [31:0]           opts_o
);

    localparam logic [31:0] SEMA_MASK = 32'((64'd1 << SEMA_W) - 64'd1);

    logic [REGS_PER_CH-1:0][31:0] regs_q;

    // Write-mask of each register in the window.
    function automatic logic [31:0] reg_mask(input int idx);
        return (idx == 1) ? SEMA_MASK : 32'hFFFF_FFFF;
    endfunction

    // Update each register from bus writes, clearing on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            regs_q <= '0;
        end else begin
            for (int r = 0; r < REGS_PER_CH; r++) begin
                if (we && sel[r])
                    regs_q[r] <= alias_apply(regs_q[r], wdata, reg_mask(r), op);
            end
        end
    end

    assign ptr_o  = regs_q[0];
    assign sema_o = regs_q[1][SEMA_W-1:0];
    assign stat_o = regs_q[2];
    assign opts_o = regs_q[3];

    // R9: without a write to this window the registers keep their value.
    assert_win_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !(we && (|sel))) |=> $stable(regs_q));

    // R11: soft reset empties the window by the next cycle.
    assert_win_srst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (regs_q == '0));

    // R9: the semaphore never holds bits beyond its width.
    assert_sema_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[1] & ~SEMA_MASK) == 32'h0);

endmodule

// File: rtl/regbank_irq.sv
// Per-channel interrupt flags and the combined interrupt line.
// Flags set on a one-cycle done pulse and drop only on a clear request;
// a pulse beats a clear in the same cycle, soft reset beats both.
module regbank_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic [NUM_CH-1:0] done_i,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] irq_en,
    output logic [NUM_CH-1:0] flags_o,
    output logic              irq_o
);

    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] clr_mask;

    // Bits that the current bus access asks to clear.
    assign clr_mask = clr_we ? clr_bits : '0;

    // Latch done pulses, apply clears, give pulses the last word.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) flags_q <= '0;
        else                flags_q <= (flags_q & ~clr_mask) | done_i;
    end

    assign flags_o = flags_q;
    // Mask the flags with their enables and merge into one line.
    assign irq_o   = |(flags_q & irq_en);

    // R6: a done pulse outside soft reset is visible as a flag next cycle.
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && (|done_i)) |=> ((flags_q & $past(done_i)) == $past(done_i)));

    // R6: a flag only falls after a clear request or a soft reset.
    assert_flag_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_q) & ~flags_q)) |-> ($past(clr_we) || $past(srst)));

endmodule

// File: rtl/coproc_regbank.sv
// Register bank of a multi-channel co-processor.
// Decodes the register bus, keeps the global control, status and channel
// control registers, instantiates one window per channel and the interrupt
// collector. Reads are combinational and free of side effects; writes take
// effect at the clock edge of the bus_wr cycle.
module coproc_regbank
    import regbank_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int NUM_CH         = 4,
    parameter int SEMA_W         = 8,
    parameter bit CIPHER_PRESENT = 1'b1,
    parameter bit HASH_PRESENT   = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_CH-1:0]        ch_done_i,
    input  logic [NUM_CH-1:0]        ch_ready_i,
    input  logic [3:0]               cur_ch_i,
    input  logic                     key_ready_i,
    output logic                     soft_rst_o,
    output logic                     clk_gate_o,
    output logic                     gather_wr_o,
    output logic                     ctx_cache_o,
    output logic                     ctx_switch_o,
    output logic [NUM_CH-1:0]        ch_enable_o,
    output logic [NUM_CH-1:0]        ch_high_prio_o,
    output logic                     ch0_irq_merge_o,
    output logic [NUM_CH*32-1:0]     cmd_ptr_o,
    output logic [NUM_CH*SEMA_W-1:0] sema_o,
    output logic [NUM_CH*32-1:0]     ch_status_o,
    output logic [NUM_CH*32-1:0]     ch_opts_o,
    output logic                     irq_o
);

    localparam int SEL_N = GLOBAL_REGS + REGS_PER_CH * NUM_CH;
    localparam logic [31:0] CH_BITS     = 32'((64'd1 << NUM_CH) - 64'd1);
    localparam logic [31:0] SRST_BIT    = 32'h8000_0000;
    localparam logic [31:0] CTRL_WMASK  = 32'hC0E0_0000 | CH_BITS;
    localparam logic [31:0] CHCTL_WMASK = 32'h0001_0000 | CH_BITS | (CH_BITS << 8);
    localparam logic [31:0] CTRL_CONST  =
        {2'b00, CIPHER_PRESENT, HASH_PRESENT, 28'h0};

    logic [SEL_N-1:0]        sel;
    alias_op_e               op;
    logic [31:0]             ctrl_q;
    logic [31:0]             chctl_q;
    logic                    srst;
    logic [NUM_CH-1:0]       flags;
    logic                    stat_clr;
    logic [SEL_N-1:0][31:0]  rd_vals;
    logic [3:0]              ready4;
    logic [3:0]              flags4;

    regbank_addr_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) dec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .sel   (sel),
        .op    (op)
    );

    assign srst = ctrl_q[31];

    // Control register: soft reset survives itself, everything else clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && sel[0]) begin
            ctrl_q <= srst ? (alias_apply(ctrl_q, bus_wdata, CTRL_WMASK, op) & SRST_BIT)
                           :  alias_apply(ctrl_q, bus_wdata, CTRL_WMASK, op);
        end else if (srst) begin
            ctrl_q <= ctrl_q & SRST_BIT;
        end
    end

    // Channel control register with soft reset priority.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)         chctl_q <= '0;
        else if (bus_wr && sel[2])  chctl_q <= alias_apply(chctl_q, bus_wdata, CHCTL_WMASK, op);
    end

    // Only the clear alias of the status register touches the flags.
    assign stat_clr = bus_wr && sel[1] && (op == OP_CLR);

    regbank_irq #(
        .NUM_CH (NUM_CH)
    ) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .done_i   (ch_done_i),
        .clr_we   (stat_clr),
        .clr_bits (bus_wdata[NUM_CH-1:0]),
        .irq_en   (ctrl_q[NUM_CH-1:0]),
        .flags_o  (flags),
        .irq_o    (irq_o)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_win
            logic [31:0]       w_ptr;
            logic [SEMA_W-1:0] w_sema;
            logic [31:0]       w_stat;
            logic [31:0]       w_opts;

            regbank_chan_win #(
                .SEMA_W (SEMA_W)
            ) win_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .srst   (srst),
                .we     (bus_wr),
                .sel    (sel[GLOBAL_REGS + REGS_PER_CH*c +: REGS_PER_CH]),
                .op     (op),
                .wdata  (bus_wdata),
                .ptr_o  (w_ptr),
                .sema_o (w_sema),
                .stat_o (w_stat),
                .opts_o (w_opts)
            );

            assign cmd_ptr_o[c*32 +: 32]        = w_ptr;
            assign sema_o[c*SEMA_W +: SEMA_W]   = w_sema;
            assign ch_status_o[c*32 +: 32]      = w_stat;
            assign ch_opts_o[c*32 +: 32]        = w_opts;

            assign rd_vals[GLOBAL_REGS + REGS_PER_CH*c + 0] = w_ptr;
            assign rd_vals[GLOBAL_REGS + REGS_PER_CH*c + 1] = 32'(w_sema);
            assign rd_vals[GLOBAL_REGS + REGS_PER_CH*c + 2] = w_stat;
            assign rd_vals[GLOBAL_REGS + REGS_PER_CH*c + 3] = w_opts;
        end
    endgenerate

    assign ready4 = 4'(ch_ready_i);
    assign flags4 = 4'(flags);

    assign rd_vals[0] = ctrl_q | CTRL_CONST;
    assign rd_vals[1] = {3'b000, key_ready_i, cur_ch_i, 4'h0, ready4, 12'h000, flags4};
    assign rd_vals[2] = chctl_q;

    // Read mux: OR of the selected value, zero when idle or unmapped.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int k = 0; k < SEL_N; k++) begin
                bus_rdata = bus_rdata | ({32{sel[k]}} & rd_vals[k]);
            end
        end
    end

    assign soft_rst_o      = ctrl_q[31];
    assign clk_gate_o      = ctrl_q[30];
    assign gather_wr_o     = ctrl_q[23];
    assign ctx_cache_o     = ctrl_q[22];
    assign ctx_switch_o    = ctrl_q[21];
    assign ch_enable_o     = chctl_q[NUM_CH-1:0];
    assign ch_high_prio_o  = chctl_q[8 +: NUM_CH];
    assign ch0_irq_merge_o = chctl_q[16];

    // R11: one cycle of soft reset empties the global registers and the line.
    assert_srst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ctrl_q[30:0] == 31'h0 && chctl_q == 32'h0 && !irq_o));

    // R10: with every enable low the interrupt stays low.
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[NUM_CH-1:0] == '0) |-> !irq_o);

    // R12: idle bus returns zero data.
    assert_rd_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 32'h0));

    // R5: the presence bits never drift from the build constants.
    assert_const_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel[0]) |-> (bus_rdata[29:28] == {CIPHER_PRESENT, HASH_PRESENT}));

endmodule

// File: tb/coproc_regbank_tb_top.sv
`timescale 1ns/1ps
module coproc_regbank_tb_top;

    localparam int AW = 12;
    localparam int NC = 4;
    localparam int SW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     ch_done = '0;
    logic [NC-1:0]     ch_ready = '0;
    logic [3:0]        cur_ch = '0;
    logic              key_ready = 1'b0;
    logic              soft_rst_o, clk_gate_o, gather_wr_o, ctx_cache_o, ctx_switch_o;
    logic [NC-1:0]     ch_enable_o, ch_high_prio_o;
    logic              ch0_irq_merge_o;
    logic [NC*32-1:0]  cmd_ptr_o, ch_status_o, ch_opts_o;
    logic [NC*SW-1:0]  sema_o;
    logic              irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the registers.
    logic [31:0] m_ctrl, m_chctl;
    logic [3:0]  m_flags;
    logic [31:0] m_ch [16];

    localparam logic [31:0] CMASK   = 32'hC0E0_000F;
    localparam logic [31:0] CCMASK  = 32'h0001_0F0F;
    localparam logic [31:0] CCONST  = 32'h2000_0000;

    always #10 clk = ~clk;

    coproc_regbank #(
        .ADDR_W(AW), .NUM_CH(NC), .SEMA_W(SW),
        .CIPHER_PRESENT(1'b1), .HASH_PRESENT(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ch_done_i(ch_done), .ch_ready_i(ch_ready), .cur_ch_i(cur_ch),
        .key_ready_i(key_ready), .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o),
        .gather_wr_o(gather_wr_o), .ctx_cache_o(ctx_cache_o),
        .ctx_switch_o(ctx_switch_o), .ch_enable_o(ch_enable_o),
        .ch_high_prio_o(ch_high_prio_o), .ch0_irq_merge_o(ch0_irq_merge_o),
        .cmd_ptr_o(cmd_ptr_o), .sema_o(sema_o), .ch_status_o(ch_status_o),
        .ch_opts_o(ch_opts_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] alias_f(input logic [31:0] cur, input logic [31:0] d,
                                            input logic [31:0] mask, input logic [1:0] op);
        logic [31:0] nv;
        case (op)
            2'd0: nv = d;
            2'd1: nv = cur | d;
            2'd2: nv = cur & ~d;
            default: nv = cur ^ d;
        endcase
        return (cur & ~mask) | (nv & mask);
    endfunction

    // -1 unmapped, 0 control, 1 status, 2 channel control, 3+4c+r window.
    function automatic int reg_idx(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a[11:4] <= 8'd2) return int'(a[11:4]);
        if (a >= 12'h100 && a < 12'h200) return 3 + 4 * int'((a - 12'h100) >> 6) + int'(a[5:4]);
        return -1;
    endfunction

    function automatic logic [AW-1:0] addr_of(input int k, input logic [1:0] op);
        logic [AW-1:0] base;
        if (k < 3) base = AW'(k * 16);
        else       base = AW'(256 + ((k - 3) / 4) * 64 + ((k - 3) % 4) * 16);
        return base | AW'({op, 2'b00});
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        int k = reg_idx(a);
        if (k == 0) return m_ctrl | CCONST;
        if (k == 1) return {3'b000, key_ready, cur_ch, 4'h0, ch_ready, 12'h000, m_flags};
        if (k == 2) return m_chctl;
        if (k >= 3) return m_ch[k-3];
        return 32'h0;
    endfunction

    task automatic model_step(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                              input logic [3:0] ev);
        bit sr = m_ctrl[31];
        int k = wr ? reg_idx(a) : -1;
        logic [1:0] op = a[3:2];
        bit clr = (k == 1) && (op == 2'd2);
        logic [31:0] nv;
        m_flags = sr ? 4'h0 : ((m_flags & ~(clr ? d[3:0] : 4'h0)) | ev);
        if (k == 0) begin
            nv = alias_f(m_ctrl, d, CMASK, op);
            m_ctrl = sr ? (nv & 32'h8000_0000) : nv;
        end else if (sr) begin
            m_ctrl = m_ctrl & 32'h8000_0000;
        end
        if (sr) m_chctl = 32'h0;
        else if (k == 2) m_chctl = alias_f(m_chctl, d, CCMASK, op);
        for (int j = 0; j < 16; j++) begin
            if (sr) m_ch[j] = 32'h0;
            else if (k == j + 3) m_ch[j] = alias_f(m_ch[j], d, (j % 4 == 1) ? 32'h3F : 32'hFFFF_FFFF, op);
        end
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One bus cycle: optional write plus done pulses.
    task automatic tick(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [3:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ch_done = ev; bus_rd = 1'b0;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; ch_done = '0;
        model_step(wr, a, d, ev);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        tick(1'b1, a, d, 4'h0);
    endtask

    task automatic rd_check(input string tag, input logic [AW-1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        check32(tag, bus_rdata, exp_read(a));
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        model_step(1'b0, a, 32'h0, 4'h0);
    endtask

    task automatic irq_check(input string tag);
        @(negedge clk);
        #2;
        check32(tag, {31'h0, irq_o}, {31'h0, |(m_flags & m_ctrl[3:0])});
    endtask

    task automatic outputs_check();
        @(negedge clk);
        #2;
        check32("R5 ctrl outputs", {27'h0, soft_rst_o, clk_gate_o, gather_wr_o, ctx_cache_o, ctx_switch_o},
                {27'h0, m_ctrl[31], m_ctrl[30], m_ctrl[23], m_ctrl[22], m_ctrl[21]});
        check32("R8 chctl outputs", {19'h0, ch0_irq_merge_o, 4'h0, ch_high_prio_o, 4'h0, ch_enable_o},
                {19'h0, m_chctl[16], 4'h0, m_chctl[11:8], 4'h0, m_chctl[3:0]});
        for (int c = 0; c < NC; c++) begin
            check32("R9 cmd_ptr_o", cmd_ptr_o[c*32 +: 32], m_ch[4*c]);
            check32("R9 sema_o", 32'(sema_o[c*SW +: SW]), m_ch[4*c+1]);
            check32("R9 ch_status_o", ch_status_o[c*32 +: 32], m_ch[4*c+2]);
            check32("R9 ch_opts_o", ch_opts_o[c*32 +: 32], m_ch[4*c+3]);
        end
    endtask

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed_v;
        m_ctrl = 0; m_chctl = 0; m_flags = 0;
        for (int j = 0; j < 16; j++) m_ch[j] = 0;
        seed_v = $urandom(32'h1234_5678);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state.
        rd_check("R5 reset control", 12'h000);
        rd_check("R6 reset status", 12'h010);
        irq_check("R10 reset irq");
        outputs_check();

        // Alias operations on the control register.
        wr(12'h000, 32'h7FFF_FFFF);
        rd_check("R1 direct write control", 12'h000);
        check32("R1 literal", exp_read(12'h000), 32'h60E0_000F);
        wr(12'h008, 32'h4000_0001);
        rd_check("R3 clear alias control", 12'h000);
        wr(12'h004, 32'h0000_0001);
        rd_check("R2 set alias control", 12'h000);
        wr(12'h00C, 32'h3060_0003);
        rd_check("R4 toggle alias and R5 constants", 12'h000);
        outputs_check();

        // Channel control.
        wr(12'h020, 32'hFFFF_FFFF);
        rd_check("R8 channel control mask", 12'h020);
        check32("R8 literal", exp_read(12'h020), 32'h0001_0F0F);
        wr(12'h02C, 32'h0000_0101);
        rd_check("R8 toggle channel control", 12'h020);

        // Channel windows.
        wr(12'h180, 32'hDEAD_BEEF);
        wr(12'h150, 32'h0000_FFFF);
        wr(12'h1E0, 32'h0000_00F0);
        wr(12'h1E4, 32'h0000_000F);
        wr(12'h130, 32'hA5A5_0000);
        wr(12'h13C, 32'hFFFF_FFFF);
        rd_check("R9 ch2 pointer", 12'h180);
        rd_check("R9 ch1 semaphore width", 12'h150);
        rd_check("R9 ch3 status set alias", 12'h1E0);
        rd_check("R9 ch0 options toggle", 12'h130);
        outputs_check();

        // Flags and interrupt.
        wr(12'h000, 32'h0000_0000);
        tick(1'b0, 12'h0, 32'h0, 4'b0010);
        rd_check("R6 flag set by pulse", 12'h010);
        irq_check("R10 flag without enable");
        wr(12'h010, 32'h0000_0000);
        wr(12'h014, 32'h0000_000F);
        wr(12'h01C, 32'h0000_000F);
        rd_check("R6 direct set toggle ignored", 12'h010);
        wr(12'h004, 32'h0000_0002);
        irq_check("R10 enabled flag raises irq");
        tick(1'b1, 12'h018, 32'h0000_0002, 4'b0010);
        rd_check("R6 pulse beats clear", 12'h010);
        irq_check("R10 irq held");
        wr(12'h018, 32'h0000_0002);
        rd_check("R6 clear alias", 12'h010);
        irq_check("R10 irq drops");

        // Read-only status fields.
        ch_ready = 4'b1010; cur_ch = 4'h5; key_ready = 1'b1;
        rd_check("R7 status inputs", 12'h010);
        check32("R7 literal", exp_read(12'h010), 32'h150A_0000);

        // Reads: aliases, unmapped, misaligned, no side effects.
        tick(1'b0, 12'h0, 32'h0, 4'b0100);
        rd_check("R12 read via clear alias", 12'h018);
        rd_check("R12 read repeated no side effect", 12'h018);
        rd_check("R12 unmapped global", 12'h030);
        rd_check("R12 past last window", 12'h200);
        rd_check("R12 misaligned", 12'h181);
        rd_check("R12 channel alias read", 12'h188);
        @(negedge clk); #2;
        check32("R12 idle rdata", bus_rdata, 32'h0);

        // Soft reset.
        wr(12'h004, 32'h8000_0000);
        tick(1'b1, 12'h180, 32'h1111_1111, 4'b1111);
        rd_check("R11 control during soft reset", 12'h000);
        check32("R11 literal", exp_read(12'h000), 32'hA000_0000);
        rd_check("R11 window cleared", 12'h180);
        rd_check("R11 flags cleared", 12'h010);
        outputs_check();
        wr(12'h008, 32'h8000_0000);
        wr(12'h180, 32'h2222_2222);
        rd_check("R11 writes resume", 12'h180);

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            int k = int'($urandom_range(18, 0));
            logic [1:0] op = 2'($urandom_range(3, 0));
            logic [31:0] d = $urandom();
            logic [3:0] ev = ($urandom_range(3, 0) == 0) ? 4'($urandom()) : 4'h0;
            if (k == 0) d[31] = 1'b0;
            if ($urandom_range(7, 0) == 0) begin
                ch_ready = 4'($urandom()); cur_ch = 4'($urandom()); key_ready = 1'($urandom());
            end
            tick(1'b1, addr_of(k, op), d, ev);
            rd_check("R1 R2 R3 R4 random readback",
                     addr_of(int'($urandom_range(18, 0)), 2'($urandom_range(3, 0))));
            irq_check("R10 random irq");
            if (i % 50 == 0) outputs_check();
        end

        finished = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule